// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block is a watchdog for a small controller core. It stays dormant after a hardware reset and is only brought to life when software writes a two-byte key, 1EH followed by E1H, to a write-only register address. The same key pair then acts as the service operation that restarts the count. Once running, the watchdog cannot be switched off by software. The only ways out are a hardware reset or its own expiry.

While armed, a counter advances on each machine-cycle tick. When the count reaches its all-ones value, the block raises a one-cycle device reset request and returns to the dormant state. It can also drive the external reset pin high for a fixed number of oscillator periods, and a configuration bit turns that drive off. Counting pauses in power-down. After a wake by interrupt, counting stays paused until the wake line goes high again. A second configuration bit makes idle mode pause the count as well.

Top module: `wdt_seq_guard`

## Requirements
- R1: After a synchronous active-low reset, the watchdog is disarmed, both outputs are low, and no number of machine-cycle ticks produces a reset request.
- R2: A write of 1EH to address A6H, followed directly (as the next write to A6H) by a write of E1H to A6H, arms the watchdog with a count of zero at the edge of the E1H write.
- R3: While armed, the same 1EH/E1H pair returns the count to zero at the edge of the E1H write.
- R4: A write to A6H of any value other than E1H after 1EH cancels the pending key, so a later E1H alone does nothing. A 1EH arriving while the key is pending restarts it. An E1H with no pending 1EH does nothing. Writes to other addresses neither advance nor cancel the key.
- R5: While armed and not paused, the count advances by one on each cycle with mc_tick high. With the default 14-bit width, the edge after the count reaches 3FFFH raises wdt_reset for exactly one cycle. With ticks on every cycle, that is 16384 cycles after arming.
- R6: Once armed, no sequence of register writes disarms the watchdog.
- R7: An expiry disarms the watchdog, so no further reset request follows without a new arming.
- R8: With cfg_pin_off low, rst_pin_drive rises together with wdt_reset and stays high for 98 osc_tick periods. With osc_tick high on every cycle, that is 98 cycles.
- R9: With cfg_pin_off high when the expiry occurs, rst_pin_drive stays low.
- R10: In idle mode the count keeps running when cfg_freeze_idle is low, and is held while idle_mode and cfg_freeze_idle are both high.
- R11: The count is held while pd_mode is high. After pd_mode falls, it stays held until wake_irq_n is seen high, and it resumes on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| mc_tick | input | 1 | One-cycle strobe per machine cycle |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| idle_mode | input | 1 | Core is in idle mode |
| pd_mode | input | 1 | Core is in power-down mode |
| wake_irq_n | input | 1 | Level of the active-low wake interrupt line |
| cfg_freeze_idle | input | 1 | Hold the count while in idle mode |
| cfg_pin_off | input | 1 | Suppress the reset-pin drive on expiry |
| wdt_reset | output | 1 | One-cycle device reset request on expiry |
| rst_pin_drive | output | 1 | High while the reset pin is driven after expiry |

## Verification
The key detector is probed with aborted, repeated and misaddressed pairs. A detector that fails to cancel on a wrong byte, or that lets writes to other addresses break the pair, arms when it should not, or stays dormant when it should arm. Expiry timing is measured in exact cycles from arming or servicing. Off-by-one errors in the terminal count, a service that fails to clear the count, or a count that ignores the tick show up as a wrong cycle number. The idle, power-down and wake-hold tests each pause the count for a known number of cycles. A design that keeps counting, or that releases the hold on the falling edge of pd_mode instead of when the wake line goes high, expires too early. The 98-cycle pin pulse, its suppression, and the absence of a second expiry after an overflow are checked directly.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the sequence-armed watchdog.
// Assumes an 8-bit register write port.
package wdt_pkg;
    localparam int unsigned WDT_ADDR_W = 8;
    localparam int unsigned WDT_DATA_W = 8;
    localparam logic [7:0]  WDT_REG_ADDR = 8'hA6;
    localparam logic [7:0]  WDT_KEY_FIRST = 8'h1E;
    localparam logic [7:0]  WDT_KEY_SECOND = 8'hE1;

    typedef enum logic {
        KEY_WAIT    = 1'b0,
        KEY_PENDING = 1'b1
    } key_state_t;
endpackage

// File: rtl/wdt_unlock.sv
// Key-pair detector and arm flag.
// Watches writes to one register address and produces a service strobe
// when the second key directly follows the first. Assumes clr wins over
// any write arriving in the same cycle.
module wdt_unlock
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W = WDT_ADDR_W,
    parameter int unsigned DATA_W = WDT_DATA_W,
    parameter logic [ADDR_W-1:0] REG_ADDR = WDT_REG_ADDR,
    parameter logic [DATA_W-1:0] KEY_A = WDT_KEY_FIRST,
    parameter logic [DATA_W-1:0] KEY_B = WDT_KEY_SECOND
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              service,
    output logic              armed
);
    key_state_t key_q;
    logic       hit;

    // Decode a write that targets the watchdog register.
    always_comb begin
        hit     = wr_en && (wr_addr == REG_ADDR);
        service = hit && (key_q == KEY_PENDING) && (wr_data == KEY_B);
    end

    // Track whether the first key byte is waiting for its partner.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            key_q <= KEY_WAIT;
        end else if (hit) begin
            key_q <= (wr_data == KEY_A) ? KEY_PENDING : KEY_WAIT;
        end
    end

    // Arm on the first complete pair; only reset or expiry disarms.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            armed <= 1'b0;
        end else if (service) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/wdt_counter.sv
// Machine-cycle counter with low-power gating.
// Counts while armed and not paused. The pause sources are power-down,
// the post-wake hold and (optionally) idle. Flags expiry when the count
// sits at its all-ones value. Assumes a service clears the count even
// on the cycle it arms.
module wdt_counter #(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             service,
    input  logic             mc_tick,
    input  logic             idle_mode,
    input  logic             cfg_freeze_idle,
    input  logic             pd_mode,
    input  logic             wake_irq_n,
    output logic [CNT_W-1:0] count,
    output logic             fire
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic wake_hold_q;
    logic run;

    // Decide whether this machine cycle may advance the count.
    always_comb begin
        run  = !pd_mode && !wake_hold_q && !(idle_mode && cfg_freeze_idle);
        fire = armed && (count == CNT_MAX);
    end

    // Hold counting from power-down entry until the wake line is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_hold_q <= 1'b0;
        end else if (pd_mode) begin
            wake_hold_q <= 1'b1;
        end else if (wake_irq_n) begin
            wake_hold_q <= 1'b0;
        end
    end

    // Advance, clear on service or expiry, stay at zero while disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed || service || fire) begin
            count <= '0;
        end else if (run && mc_tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_pulse.sv
// Reset-pin pulse stretcher.
// Loads a period count on expiry, unless the pin is configured off.
// Counts it down on oscillator ticks and drives high while it is non-zero.
module wdt_pulse #(
    parameter int unsigned PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic pin_off,
    input  logic osc_tick,
    output logic drive
);
    localparam int unsigned PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);

    logic [PW-1:0] left_q;

    // Load on expiry, then count oscillator periods down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= pin_off ? '0 : LEN;
        end else if (osc_tick && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    // The pin is driven while periods remain.
    always_comb drive = (left_q != '0);
endmodule

// File: rtl/wdt_seq_guard.sv
// Sequence-armed watchdog top level.
// Joins the key detector, the gated counter and the pin pulse stretcher,
// and registers the one-cycle device reset request. Assumes every input
// is synchronous to clk.
module wdt_seq_guard
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 14,
    parameter int unsigned PULSE_LEN = 98,
    parameter logic [7:0] REG_ADDR = WDT_REG_ADDR
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mc_tick,
    input  logic       osc_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       idle_mode,
    input  logic       pd_mode,
    input  logic       wake_irq_n,
    input  logic       cfg_freeze_idle,
    input  logic       cfg_pin_off,
    output logic       wdt_reset,
    output logic       rst_pin_drive
);
    logic             service;
    logic             armed;
    logic             fire;
    logic [CNT_W-1:0] count;

    wdt_unlock #(
        .ADDR_W(8), .DATA_W(8), .REG_ADDR(REG_ADDR),
        .KEY_A(WDT_KEY_FIRST), .KEY_B(WDT_KEY_SECOND)
    ) u_unlock (
        .clk(clk), .rst_n(rst_n), .clr(fire),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .service(service), .armed(armed)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .armed(armed), .service(service),
        .mc_tick(mc_tick), .idle_mode(idle_mode),
        .cfg_freeze_idle(cfg_freeze_idle), .pd_mode(pd_mode),
        .wake_irq_n(wake_irq_n), .count(count), .fire(fire)
    );

    wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .load(fire), .pin_off(cfg_pin_off),
        .osc_tick(osc_tick), .drive(rst_pin_drive)
    );

    // Register the one-cycle device reset request on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_reset <= 1'b0;
        end else begin
            wdt_reset <= fire;
        end
    end
endmodule

// File: rtl/wdt_seq_guard_checker.sv
// Temporal checks for the watchdog, attached to every instance by bind.
module wdt_seq_guard_checker #(
    parameter int unsigned CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pd_mode,
    input logic             cfg_pin_off,
    input logic             wdt_reset,
    input logic             rst_pin_drive,
    input logic             armed,
    input logic             service,
    input logic             fire,
    input logic [CNT_W-1:0] count
);
    assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |=> !wdt_reset);

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !service && !fire) |=>
        ((count == $past(count)) || (count == CNT_W'($past(count) + 1'b1))));

    assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |-> !armed);

    assert_dormant_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (count == '0));

    assert_pin_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pin_drive) |-> wdt_reset);

    assert_pin_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_reset && $past(cfg_pin_off)) |-> !rst_pin_drive);

    assert_pd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_mode && !service && !fire) |=> $stable(count));
endmodule

bind wdt_seq_guard wdt_seq_guard_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pd_mode(pd_mode), .cfg_pin_off(cfg_pin_off),
    .wdt_reset(wdt_reset), .rst_pin_drive(rst_pin_drive), .armed(armed),
    .service(service), .fire(fire), .count(count)
);

// File: tb/wdt_seq_guard_bench.sv
module wdt_seq_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b1;
    logic       osc_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       idle_mode = 1'b0;
    logic       pd_mode = 1'b0;
    logic       wake_irq_n = 1'b1;
    logic       cfg_freeze_idle = 1'b0;
    logic       cfg_pin_off = 1'b0;
    logic       rst_b, pin_b, rst_s, pin_s;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    wdt_seq_guard u_wdt_seq_guard (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .osc_tick(osc_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .idle_mode(idle_mode), .pd_mode(pd_mode), .wake_irq_n(wake_irq_n),
        .cfg_freeze_idle(cfg_freeze_idle), .cfg_pin_off(cfg_pin_off),
        .wdt_reset(rst_b), .rst_pin_drive(pin_b)
    );

    // Narrow copy (5-bit count, expiry 32 ticks after arming) for short tests.
    wdt_seq_guard #(.CNT_W(5)) u_small (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .osc_tick(osc_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .idle_mode(idle_mode), .pd_mode(pd_mode), .wake_irq_n(wake_irq_n),
        .cfg_freeze_idle(cfg_freeze_idle), .cfg_pin_off(cfg_pin_off),
        .wdt_reset(rst_s), .rst_pin_drive(pin_s)
    );

    // Key-pair vectors: four {addr,data} slots (addr 00 = no write), then whether it arms.
    localparam logic [64:0] VEC [8] = '{
        {1'b1, 64'hA61E_A6E1_0000_0000},
        {1'b0, 64'hA6E1_A61E_0000_0000},
        {1'b0, 64'hA61E_A655_A6E1_0000},
        {1'b1, 64'hA61E_A655_A61E_A6E1},
        {1'b0, 64'hA61E_90E1_0000_0000},
        {1'b1, 64'hA61E_9033_A6E1_0000},
        {1'b1, 64'hA61E_A61E_A6E1_0000},
        {1'b0, 64'h901E_A6E1_0000_0000}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_mode = 1'b0; pd_mode = 1'b0; wake_irq_n = 1'b1;
        cfg_freeze_idle = 1'b0; cfg_pin_off = 1'b0; mc_tick = 1'b1; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic arm();
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'hE1);
    endtask

    // Cycles from arming until the reset request is seen, with per-mode stimulus.
    task automatic measure(input int mode, input bit big, input int limit, output int n);
        n = -1;
        for (int k = 1; k <= limit; k++) begin
            wr_en = 1'b0; mc_tick = 1'b1; idle_mode = 1'b0; pd_mode = 1'b0; wake_irq_n = 1'b1;
            case (mode)
                1: idle_mode = 1'b1;
                2: begin cfg_freeze_idle = 1'b1; idle_mode = (k <= 10); end
                3: begin pd_mode = (k <= 10); wake_irq_n = (k > 15); end
                4: pd_mode = (k <= 10);
                5: if (k == 21 || k == 22) begin
                       wr_en = 1'b1; wr_addr = 8'hA6; wr_data = (k == 21) ? 8'h1E : 8'hE1;
                   end
                6: if (k >= 5 && k <= 8) begin
                       wr_en = 1'b1;
                       wr_addr = (k == 8) ? 8'h90 : 8'hA6;
                       wr_data = (k == 5) ? 8'h00 : (k == 7) ? 8'h1E : 8'hE1;
                   end
                7: mc_tick = (k > 8);
                default: ;
            endcase
            @(posedge clk);
            #1;
            if (big ? rst_b : rst_s) begin
                n = k;
                break;
            end
        end
        wr_en = 1'b0; mc_tick = 1'b1; idle_mode = 1'b0; pd_mode = 1'b0;
        wake_irq_n = 1'b1; cfg_freeze_idle = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        int seen;
        do_reset();
        #1;
        // R1: reset state and no expiry while dormant.
        check("R1 wdt_reset after reset", rst_b, 0);
        check("R1 pin after reset", pin_b, 0);
        seen = 0;
        repeat (60) begin @(posedge clk); #1; if (rst_s || pin_s) seen = 1; end
        check("R1 dormant never expires", seen, 0);

        // R2 R4: table of key-pair vectors.
        for (int v = 0; v < 8; v++) begin
            do_reset();
            for (int s = 3; s >= 0; s--) begin
                logic [15:0] slot;
                slot = VEC[v][s*16 +: 16];
                if (slot[15:8] != 8'h00) wr(slot[15:8], slot[7:0]);
            end
            seen = 0;
            repeat (40) begin @(posedge clk); #1; if (rst_s) seen = 1; end
            check($sformatf("R2/R4 vector %0d arms", v), seen, int'(VEC[v][64]));
        end

        // R5 R8: full-width expiry timing and pin pulse.
        do_reset();
        arm();
        measure(0, 1'b1, 20000, n);
        check("R5 expiry cycle at 3FFFH", n, 16384);
        check("R8 pin rises with reset", pin_b, 1);
        seen = 0;
        while (pin_b && seen < 300) begin seen++; @(posedge clk); #1;
            if (seen == 1) check("R5 reset one cycle", rst_b, 0); end
        check("R8 pin high cycles", seen, 98);

        // R5: machine-cycle tick gates counting.
        do_reset(); arm(); measure(7, 1'b0, 200, n);
        check("R5 ticks only on mc_tick", n, 40);

        // R3: service clears the count.
        do_reset(); arm(); measure(5, 1'b0, 200, n);
        check("R3 service restarts count", n, 54);

        // R6: writes cannot disarm.
        do_reset(); arm(); measure(6, 1'b0, 200, n);
        check("R6 no disarm by writes", n, 32);

        // R7: expiry disarms.
        seen = 0;
        repeat (80) begin @(posedge clk); #1; if (rst_s) seen = 1; end
        check("R7 no second expiry", seen, 0);

        // R9: pin drive suppressed.
        do_reset(); cfg_pin_off = 1'b1; arm(); cfg_pin_off = 1'b1;
        seen = 0;
        for (int k = 0; k < 40; k++) begin @(posedge clk); #1; if (pin_s) seen = 1; end
        check("R9 pin stays low", seen, 0);
        cfg_pin_off = 1'b0;

        // R10: idle behaviour.
        do_reset(); arm(); measure(1, 1'b0, 200, n);
        check("R10 idle counts by default", n, 32);
        do_reset(); arm(); measure(2, 1'b0, 200, n);
        check("R10 idle freeze holds count", n, 42);

        // R11: power-down and wake hold.
        do_reset(); arm(); measure(3, 1'b0, 200, n);
        check("R11 hold until wake line high", n, 48);
        do_reset(); arm(); measure(4, 1'b0, 200, n);
        check("R11 wake line already high", n, 43);

        finish_run();
    end
endmodule